// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a pin-level model of a small serial EEPROM that holds 64 words of 16 bits. A host drives a chip select, a serial clock and a data input. The block answers on a data output that has its own drive enable, so the pair forms a tri-state pin. Every command begins with a start bit, followed by a two-bit operation code and a six-bit word address. Write commands are followed by sixteen data bits. The block samples all inputs into its system clock domain and acts on each rising edge of the serial clock.

The block can read words, streaming successive addresses for as long as the clock keeps running. It can also write one word, write one value to every word, erase one word and erase every word. It holds a write-enable latch that must be set before any write or erase has effect. A write is launched when chip select falls, and an internal counter stands in for the programming time. While that counter runs, the output reports busy or ready whenever chip select is high.

Top module: `ser_eeprom`

## Requirements
- R1: While chip select is high and no command is in progress, DI values of 0 sampled on serial-clock rising edges are ignored; the first 1 is taken as the start bit.
- R2: After the start bit, two opcode bits and then six address bits (most significant first) are taken. Opcode 10 reads, 01 writes a word and 11 erases a word. Opcode 00 selects by address bits [5:4]: 11 sets the write-enable latch, 00 clears it, 01 writes all words and 10 erases all words; address bits [3:0] are ignored.
- R3: For a read, DO is driven to 0 from the clock that captures the last address bit; the 16 following rising edges present bits 15 down to 0 of the addressed word.
- R4: If clocking continues after bit 0 of a read, the next address follows with no gap, and address 63 is followed by address 0.
- R5: The write-enable latch is clear after reset and after the disable command; while it is clear, word write, write-all, erase and erase-all leave the storage unchanged. Reads work in both latch states.
- R6: A word write stores its 16 data bits at the address, replacing the old word, when chip select falls after all 16 data bits were received.
- R7: After reset every word reads 16'hFFFF. Write-all stores one value in all 64 words. Erase sets one word to 16'hFFFF, and erase-all sets every word to 16'hFFFF.
- R8: For WR_CYCLES system clocks after a write or erase is launched, DO is driven to 0 (busy) while chip select is high. After that time it is driven to 1 (ready) while chip select is high, until the next start bit is received.
- R9: While busy, no start bit is accepted, so a complete command clocked in during that time has no effect.
- R10: DO is not driven (enable 0) while chip select is low. Chip select falling before a write is launched aborts the command, and the next command starts with the start-bit hunt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock; data is taken on its rising edge |
| di_i | input | 1 | Serial data input |
| dout_o | output | 1 | Serial data output value (0 whenever not driven) |
| dout_en_o | output | 1 | Drive enable for dout_o; 0 means high impedance |

## Verification
The bench checks the dummy zero that must appear at the last address clock. A design that is one clock early or late there shifts every data bit, so each word comes back corrupted. Auto-increment is checked from address 63, where a design that does not wrap to 0 streams the wrong word. A design that drops the register reload at the end of a word repeats the same word instead of moving on. The bench also clocks a full write in while the block is busy and aborts another write part-way through its data. A design that accepts commands while busy, or that launches writes it did not fully receive, changes words that must stay as they were. Commands are also issued with the write-enable latch clear. Here a design that forgets the latch changes the storage, and one that gates reads on the latch returns wrong data.

// File: rtl/ee_pkg.sv
package ee_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_OPC,
        ST_ADDR,
        ST_RDAT,
        ST_WDAT,
        ST_HOLD
    } ee_state_e;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] SUB_WDS  = 2'b00;
    localparam logic [1:0] SUB_WRAL = 2'b01;
    localparam logic [1:0] SUB_ERAL = 2'b10;
    localparam logic [1:0] SUB_WEN  = 2'b11;

endpackage

// File: rtl/ee_sync.sv
module ee_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic cs_s,
    output logic di_s,
    output logic sk_rise,
    output logic cs_fall
);
    logic [STAGES-1:0] cs_q, sk_q, di_q;
    logic              sk_last_q, cs_last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q      <= '0;
            sk_q      <= '0;
            di_q      <= '0;
            sk_last_q <= 1'b0;
            cs_last_q <= 1'b0;
        end else begin
            cs_q      <= {cs_q[STAGES-2:0], cs_i};
            sk_q      <= {sk_q[STAGES-2:0], sk_i};
            di_q      <= {di_q[STAGES-2:0], di_i};
            sk_last_q <= sk_q[STAGES-1];
            cs_last_q <= cs_q[STAGES-1];
        end
    end

    assign cs_s    = cs_q[STAGES-1];
    assign di_s    = di_q[STAGES-1];
    assign sk_rise = sk_q[STAGES-1] & ~sk_last_q;
    assign cs_fall = ~cs_q[STAGES-1] & cs_last_q;

endmodule

// File: rtl/ee_array.sv
module ee_array #(
    parameter int AW        = 6,
    parameter int DW        = 16,
    parameter int WR_CYCLES = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic          wr_all,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          busy
);
    localparam int DEPTH = 1 << AW;
    localparam int CW    = $clog2(WR_CYCLES + 1);

    logic [DW-1:0] mem_q [DEPTH];
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (wr_req)
            cnt_d = CW'(WR_CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_word
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem_q[gi] <= '1;
                else if (wr_req && (wr_all || wr_addr == AW'(gi)))
                    mem_q[gi] <= wr_data;
            end
        end
    endgenerate

    assign rd_data = mem_q[rd_addr];
    assign busy    = (cnt_q != '0);

    AST_BUSY_AFTER_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> busy); // R8
    AST_NO_LAUNCH_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_req); // R9

endmodule

// File: rtl/ee_cmd.sv
module ee_cmd
    import ee_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          di_s,
    input  logic          sk_rise,
    input  logic          cs_fall,
    input  logic          busy,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_req,
    output logic          wr_all,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          dout_o,
    output logic          dout_en_o
);
    localparam int CNT_W = $clog2(DW + 1);

    typedef struct packed {
        ee_state_e   state;
        logic [CNT_W-1:0] cnt;
        logic [1:0]  opc;
        logic [AW-1:0] addr;
        logic [DW-1:0] sh;
        logic        wen;
        logic        arm;
        logic        arm_all;
        logic        status;
        logic        rdrv;
        logic        dout;
        logic        en;
    } cmd_regs_t;

    cmd_regs_t q, n;
    logic [AW-1:0] a_full;

    always_comb begin
        n       = q;
        wr_req  = 1'b0;
        a_full  = {q.addr[AW-2:0], di_s};
        rd_addr = (q.state == ST_RDAT) ? AW'(q.addr + 1'b1) : a_full;

        if (!cs_s) begin
            if (cs_fall && q.arm && q.state == ST_HOLD) begin
                wr_req   = 1'b1;
                n.status = 1'b1;
            end
            n.state = ST_HUNT;
            n.arm   = 1'b0;
            n.rdrv  = 1'b0;
            n.cnt   = '0;
        end else if (sk_rise) begin
            case (q.state)
                ST_HUNT: begin
                    if (di_s && !busy) begin
                        n.state  = ST_OPC;
                        n.cnt    = '0;
                        n.status = 1'b0;
                    end
                end
                ST_OPC: begin
                    n.opc = {q.opc[0], di_s};
                    n.cnt = q.cnt + 1'b1;
                    if (q.cnt == CNT_W'(1)) begin
                        n.state = ST_ADDR;
                        n.cnt   = '0;
                    end
                end
                ST_ADDR: begin
                    n.addr = a_full;
                    n.cnt  = q.cnt + 1'b1;
                    if (q.cnt == CNT_W'(AW - 1)) begin
                        n.cnt     = '0;
                        n.arm_all = 1'b0;
                        n.state   = ST_HOLD;
                        case (q.opc)
                            OPC_READ: begin
                                n.state = ST_RDAT;
                                n.rdrv  = 1'b1;
                                n.dout  = 1'b0;
                                n.sh    = rd_data;
                            end
                            OPC_WRITE: n.state = ST_WDAT;
                            OPC_ERASE: begin
                                n.arm = q.wen;
                                n.sh  = '1;
                            end
                            default: begin
                                case (a_full[AW-1:AW-2])
                                    SUB_WEN:  n.wen = 1'b1;
                                    SUB_WDS:  n.wen = 1'b0;
                                    SUB_WRAL: begin
                                        n.state   = ST_WDAT;
                                        n.arm_all = 1'b1;
                                    end
                                    default: begin
                                        n.arm     = q.wen;
                                        n.arm_all = 1'b1;
                                        n.sh      = '1;
                                    end
                                endcase
                            end
                        endcase
                    end
                end
                ST_RDAT: begin
                    n.dout = q.sh[DW-1];
                    n.sh   = {q.sh[DW-2:0], 1'b0};
                    n.cnt  = q.cnt + 1'b1;
                    if (q.cnt == CNT_W'(DW - 1)) begin
                        n.cnt  = '0;
                        n.addr = AW'(q.addr + 1'b1);
                        n.sh   = rd_data;
                    end
                end
                ST_WDAT: begin
                    n.sh  = {q.sh[DW-2:0], di_s};
                    n.cnt = q.cnt + 1'b1;
                    if (q.cnt == CNT_W'(DW - 1)) begin
                        n.state = ST_HOLD;
                        n.arm   = q.wen;
                    end
                end
                default: ;
            endcase
        end

        n.en = cs_s && (n.rdrv || (n.status && n.state == ST_HUNT));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_HUNT;
        end else begin
            q <= n;
        end
    end

    assign wr_all    = q.arm_all;
    assign wr_addr   = q.addr;
    assign wr_data   = q.sh;
    assign dout_en_o = q.en;
    assign dout_o    = q.en & (q.rdrv ? q.dout : ~busy);

    AST_LAUNCH_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> q.wen); // R5
    AST_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && $past(!cs_s)) |-> !dout_en_o); // R10
    AST_HUNT_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> (q.state == ST_HUNT)); // R10

endmodule

// File: rtl/ser_eeprom.sv
module ser_eeprom #(
    parameter int AW          = 6,
    parameter int DW          = 16,
    parameter int WR_CYCLES   = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic dout_o,
    output logic dout_en_o
);
    logic          cs_s, di_s, sk_rise, cs_fall, busy;
    logic          wr_req, wr_all;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [DW-1:0] rd_data, wr_data;

    ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_i    (cs_i),
        .sk_i    (sk_i),
        .di_i    (di_i),
        .cs_s    (cs_s),
        .di_s    (di_s),
        .sk_rise (sk_rise),
        .cs_fall (cs_fall)
    );

    ee_cmd #(.AW(AW), .DW(DW)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (cs_s),
        .di_s      (di_s),
        .sk_rise   (sk_rise),
        .cs_fall   (cs_fall),
        .busy      (busy),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_req    (wr_req),
        .wr_all    (wr_all),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .dout_o    (dout_o),
        .dout_en_o (dout_en_o)
    );

    ee_array #(.AW(AW), .DW(DW), .WR_CYCLES(WR_CYCLES)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (wr_req),
        .wr_all  (wr_all),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .busy    (busy)
    );

    AST_LAUNCH_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !cs_s); // R6

endmodule

// File: tb/ser_eeprom_bench.sv
module ser_eeprom_bench;
    localparam int WRC = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic dout, dout_en;

    int checks = 0;
    int errors = 0;
    logic [15:0] model [64];
    logic        wen_m = 1'b0;

    logic [15:0] exp_q [$];
    logic [15:0] got_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    ser_eeprom #(.WR_CYCLES(WRC)) u_ser_eeprom (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
        .dout_o(dout), .dout_en_o(dout_en)
    );

    task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares words produced by reads against expected values
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0 && exp_q.size() > 0) begin
                logic [15:0] g, e;
                string t;
                g = got_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(g === e, t, g, e);
            end
        end
    end

    task automatic sk_bit(input logic b, output logic o);
        di = b;
        repeat (4) @(negedge clk);
        sk = 1'b1;
        repeat (4) @(negedge clk);
        o = dout;
        sk = 1'b0;
    endtask

    task automatic sel();
        di = 1'b0; sk = 1'b0; cs = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic desel();
        cs = 1'b0; di = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic header(input int lead, input logic [1:0] op, input logic [5:0] a, output logic last);
        logic o;
        for (int i = 0; i < lead; i++) sk_bit(1'b0, o);
        sk_bit(1'b1, o);
        for (int i = 1; i >= 0; i--) sk_bit(op[i], o);
        for (int i = 5; i >= 0; i--) sk_bit(a[i], o);
        last = o;
    endtask

    task automatic do_read(input int lead, input logic [5:0] a, input int nw, input string tag);
        logic o, dummy;
        logic [15:0] w;
        sel();
        header(lead, 2'b10, a, dummy);
        check(dummy === 1'b0 && dout_en === 1'b1, "R3 dummy zero", {15'd0, dummy}, 16'h0);
        for (int k = 0; k < nw; k++) begin
            for (int i = 15; i >= 0; i--) begin
                sk_bit(1'b0, o);
                w[i] = o;
            end
            exp_q.push_back(model[(a + k) % 64]);
            tag_q.push_back(tag);
            got_q.push_back(w);
        end
        desel();
    endtask

    // sends a full command, updates the model, waits out any launched write
    task automatic issue(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d);
        logic o;
        logic has_data, launched;
        has_data = (op == 2'b01) || (op == 2'b00 && a[5:4] == 2'b01);
        launched = 1'b0;
        sel();
        header(0, op, a, o);
        if (has_data) for (int i = 15; i >= 0; i--) sk_bit(d[i], o);
        desel();
        case (op)
            2'b01: if (wen_m) begin model[a] = d; launched = 1'b1; end
            2'b11: if (wen_m) begin model[a] = 16'hFFFF; launched = 1'b1; end
            default: case (a[5:4])
                2'b11: wen_m = 1'b1;
                2'b00: wen_m = 1'b0;
                2'b01: if (wen_m) begin
                    for (int i = 0; i < 64; i++) model[i] = d;
                    launched = 1'b1;
                end
                default: if (wen_m) begin
                    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
                    launched = 1'b1;
                end
            endcase
        endcase
        if (launched) repeat (WRC + 20) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic o;
        for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(dout_en === 1'b0, "R10 no drive after reset", {15'd0, dout_en}, 16'h0);

        do_read(0, 6'd0, 1, "R7 reset content");
        issue(2'b01, 6'd5, 16'h1357);
        do_read(0, 6'd5, 1, "R5 write ignored with latch clear");

        issue(2'b00, 6'b110000, 16'h0);            // enable latch
        // word write with status observation
        sel();
        header(0, 2'b01, 6'd5, o);
        for (int i = 15; i >= 0; i--) sk_bit(logic'(16'hA5C3 >> i), o);
        desel();
        model[5] = 16'hA5C3;
        sel();
        check(dout_en === 1'b1 && dout === 1'b0, "R8 busy shown", {14'd0, dout_en, dout}, 16'h2);
        // full command clocked in while busy must be dropped
        header(0, 2'b01, 6'd9, o);
        for (int i = 15; i >= 0; i--) sk_bit(logic'(16'h1234 >> i), o);
        check(dout_en === 1'b1 && dout === 1'b0, "R9 still busy after ignored command", {14'd0, dout_en, dout}, 16'h2);
        repeat (WRC) @(negedge clk);
        check(dout_en === 1'b1 && dout === 1'b1, "R8 ready shown", {14'd0, dout_en, dout}, 16'h3);
        desel();
        check(dout_en === 1'b0, "R10 released on deselect", {15'd0, dout_en}, 16'h0);
        do_read(0, 6'd9, 1, "R9 busy-time write had no effect");
        do_read(3, 6'd5, 1, "R1 R6 leading zeros then read of written word");

        issue(2'b01, 6'd6, 16'h0F0F);
        do_read(0, 6'd5, 2, "R4 stream across words");
        issue(2'b01, 6'd63, 16'h8001);
        do_read(0, 6'd63, 2, "R4 wrap 63 to 0");

        // abort a write mid data
        sel();
        header(0, 2'b01, 6'd3, o);
        for (int i = 0; i < 10; i++) sk_bit(1'b0, o);
        desel();
        sel();
        check(dout_en === 1'b0, "R10 aborted write launched nothing", {15'd0, dout_en}, 16'h0);
        desel();
        do_read(0, 6'd3, 1, "R10 aborted write kept word");

        issue(2'b11, 6'd6, 16'h0);
        do_read(0, 6'd5, 2, "R7 erase one word");
        issue(2'b00, 6'b010111, 16'h7E81);
        do_read(0, 6'd0, 1, "R7 write-all low word");
        do_read(0, 6'd40, 1, "R2 R7 write-all mid word");
        issue(2'b00, 6'b100000, 16'h0);
        do_read(0, 6'd63, 1, "R7 erase-all");

        issue(2'b00, 6'b001010, 16'h0);             // disable latch
        issue(2'b01, 6'd7, 16'h1111);
        do_read(0, 6'd7, 1, "R5 write ignored after disable");
        issue(2'b00, 6'b010000, 16'h2222);
        do_read(0, 6'd12, 1, "R5 write-all ignored after disable");

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule